// File: doc/BRIEF.md
# Next-PC and Effective-Address Generator

This block is the address arithmetic of a 32-bit fixed-length instruction pipeline. It is purely combinational. In one evaluation it takes the current program counter, the instruction word, a base register value and a few control bits. It returns the program counter of the next instruction, the effective address of a data access, the value a load-upper-immediate writes, and a flag for a misaligned data access.

A two-bit select marks the instruction class:

| Select | Class |
|---|---|
| 00 | sequential |
| 01 | conditional branch |
| 10 | jump |
| 11 | load/store |

The branch condition is evaluated elsewhere and arrives as a single taken flag. Three instruction fields feed the block:

- The 16-bit displacement sits in bits [15:0].
- The 26-bit jump target sits in bits [25:0].
- The access size is a two-bit code: 00 byte, 01 halfword, 10 or 11 word.

Top module: `addr_gen`

## Requirements
- R1: With select 00 or 11, next_pc equals pc+4, taken modulo 2^32 (0xFFFFFFFC wraps to 0).
- R2: With select 01 and the taken flag low, next_pc equals pc+4.
- R3: With select 01 and the taken flag high, next_pc equals pc+4 plus four times the sign-extended value of instr[15:0], modulo 2^32.
- R4: With select 10, next_pc equals bits [31:28] of pc+4, followed by instr[25:0], followed by two zero bits.
- R5: ea equals base plus the sign-extended value of instr[15:0], modulo 2^32, whatever the select.
- R6: lui_val equals instr[15:0] shifted left by 16, with zeros in the low half.
- R7: misalign is high only with select 11. It is high for a word access (size 10 or 11) when ea[1:0] is nonzero, and for a halfword access (size 01) when ea[0] is 1. It is never high for a byte access (size 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Current program counter |
| instr | input | 32 | Current instruction word |
| base | input | 32 | Base register value for data addressing |
| sel | input | 2 | Class: 00 sequential, 01 branch, 10 jump, 11 load/store |
| taken | input | 1 | Branch condition result |
| size | input | 2 | Access size: 00 byte, 01 half, 10/11 word |
| next_pc | output | 32 | Program counter of the next instruction |
| ea | output | 32 | Data effective address |
| lui_val | output | 32 | Upper-immediate result |
| misalign | output | 1 | Misaligned load/store access |

## Verification
A load/store produces a data effective address, an alignment verdict and a sequential next PC at the same time. In the same evaluation, the displacement field that forms the address also drives the upper-immediate value and the branch offset. The sweep holds each instruction word under every select, taken and size combination, with the base low bits stepped through all four values. It judges next_pc, ea, lui_val and misalign together against arithmetic done in the bench. Program counters at the wrap point and just below a 256 MB region edge make the jump region and the sequential wrap meet the same cases.

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int AW    = 32,
  parameter int IMM_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] instr,
  input  logic [AW-1:0] base,
  input  logic [1:0]    sel,
  input  logic          taken,
  input  logic [1:0]    size,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] lui_val,
  output logic          misalign
);
  localparam int REG_W = AW - JT_W - 2;
  localparam logic [1:0] SEL_BR  = 2'b01;
  localparam logic [1:0] SEL_JMP = 2'b10;
  localparam logic [1:0] SEL_MEM = 2'b11;

  logic [IMM_W-1:0] imm;
  logic [AW-1:0]    disp, pc_inc, br_tgt, jmp_tgt;

  assign imm     = instr[IMM_W-1:0];
  assign disp    = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
  assign pc_inc  = pc + AW'(4);
  assign br_tgt  = pc_inc + {disp[AW-3:0], 2'b00};
  assign jmp_tgt = {pc_inc[AW-1 -: REG_W], instr[JT_W-1:0], 2'b00};

  always_comb begin
    next_pc = pc_inc;
    if (sel == SEL_JMP)            next_pc = jmp_tgt;
    else if (sel == SEL_BR && taken) next_pc = br_tgt;
  end

  assign ea      = base + disp;
  assign lui_val = {imm, {(AW-IMM_W){1'b0}}};

  always_comb begin
    misalign = 1'b0;
    if (sel == SEL_MEM) begin
      unique case (size)
        2'b00:   misalign = 1'b0;
        2'b01:   misalign = ea[0];
        default: misalign = |ea[1:0];
      endcase
    end
  end
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk (
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] base,
  input logic [1:0]  sel,
  input logic        taken,
  input logic [1:0]  size,
  input logic [31:0] next_pc,
  input logic [31:0] ea,
  input logic [31:0] lui_val,
  input logic        misalign
);
  always_comb begin
    if (sel == 2'b01 && !taken)
      AST_NOT_TAKEN_SEQ: assert (next_pc - pc == 32'd4); // R2
    if (sel == 2'b10)
      AST_JUMP_ALIGNED: assert (next_pc[1:0] == 2'b00 && next_pc[27:2] == instr[25:0]); // R4
    AST_LUI_LOW_ZERO: assert (lui_val[15:0] == 16'h0 && lui_val[31:16] == instr[15:0]); // R6
    if (misalign)
      AST_MISALIGN_MEM_ONLY: assert (sel == 2'b11 && size != 2'b00); // R7
    AST_EA_LOW_HALF: assert (ea[15:0] == 16'(base[15:0] + instr[15:0])); // R5
  end
endmodule

bind addr_gen addr_gen_chk u_chk (.*);

// File: tb/addr_gen_test.sv
module addr_gen_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc = 32'h0, instr = 32'h0, base = 32'h0;
  logic [1:0]  sel = 2'b00, size = 2'b00;
  logic        taken = 1'b0;
  logic [31:0] next_pc, ea, lui_val;
  logic        misalign;
  int errors = 0, checks = 0;
  bit done = 0;

  addr_gen uut (.pc(pc), .instr(instr), .base(base), .sel(sel), .taken(taken),
                .size(size), .next_pc(next_pc), .ea(ea), .lui_val(lui_val),
                .misalign(misalign));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (pc=%h instr=%h base=%h sel=%0d taken=%0d size=%0d)",
               req, act, exp, pc, instr, base, sel, taken, size);
    end
  endtask

  logic [31:0] pcs  [4] = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h0FFF_FFFC, 32'h8000_0010};
  logic [31:0] ins  [6] = '{32'h0000_0019, 32'h03FF_FFFF, 32'h1234_8000,
                            32'hABCD_FFFF, 32'h0000_0000, 32'h0155_7FFE};
  logic [31:0] bases[3] = '{32'h0000_0000, 32'h7FFF_FFF0, 32'hFFFF_FF00};

  initial begin
    @(negedge clk);
    chk("R1 reset-state seq", next_pc, 32'h4);
    chk("R7 reset-state", {31'b0, misalign}, 32'h0);
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 6; i++)
        for (int b = 0; b < 3; b++)
          for (int lo = 0; lo < 4; lo++)
            for (int s = 0; s < 4; s++)
              for (int t = 0; t < 2; t++)
                for (int z = 0; z < 4; z++) begin
                  longint sx, inc, e_next, e_ea;
                  bit e_mis;
                  pc = pcs[p]; instr = ins[i]; base = bases[b] + 32'(lo);
                  sel = 2'(s); taken = t[0]; size = 2'(z);
                  @(negedge clk);
                  sx  = longint'(instr[15:0]);
                  if (sx >= 32768) sx = sx - 65536;
                  inc = (longint'(pc) + 4) % 64'h1_0000_0000;
                  e_ea = (longint'(base) + sx + 64'h1_0000_0000) % 64'h1_0000_0000;
                  if (s == 2)
                    e_next = (inc / 64'h1000_0000) * 64'h1000_0000 + longint'(instr[25:0]) * 4;
                  else if (s == 1 && t == 1)
                    e_next = (inc + sx * 4 + 64'h4_0000_0000) % 64'h1_0000_0000;
                  else
                    e_next = inc;
                  e_mis = 0;
                  if (s == 3) begin
                    if (z == 1) e_mis = (e_ea % 2) != 0;
                    else if (z >= 2) e_mis = (e_ea % 4) != 0;
                  end
                  if (s == 2)               chk("R4 jump target", next_pc, 32'(e_next));
                  else if (s == 1 && t == 1) chk("R3 branch taken", next_pc, 32'(e_next));
                  else if (s == 1)          chk("R2 branch not taken", next_pc, 32'(e_next));
                  else                      chk("R1 sequential", next_pc, 32'(e_next));
                  chk("R5 effective address", ea, 32'(e_ea));
                  chk("R6 upper immediate", lui_val, 32'(longint'(instr[15:0]) * 65536));
                  chk("R7 misalign", {31'b0, misalign}, {31'b0, e_mis});
                end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule